// File: doc/BRIEF.md
# Bipolar Line Monitor with Carrier-Loss Alarm

This block sits at the receive end of an alternate-mark-inversion (AMI) coded T1 line. A line receiver splits the line into two rails: one pulses for positive marks, the other for negative marks. The block samples both rails, merges them into one NRZ serial stream, and raises a flag on any mark that breaks the alternation rule. The flag is timed to the same bit on the serial output.

The block also counts consecutive zero bit times. After a fixed run of zeros it raises a carrier-loss alarm, and it drops the alarm as soon as a one arrives. When a source drives the same NRZ data onto both rails, every one shows up with both rails high. Such a bit never counts as a violation, so the data passes straight through and violation checking is in effect switched off.

Top module: `bipolar_line_monitor`

## Requirements
- R1: Both rail inputs are sampled on the falling edge of `clk`. A rail change made after that falling edge and before the next rising edge has no effect on the bit being processed.
- R2: `nrz_out` changes only on rising edges of `clk`. A bit sampled on a falling edge appears on `nrz_out` from the next rising edge onwards.
- R3: `nrz_out` is 1 for a bit time in which either rail is high. It is 0 when both rails are low.
- R4: A mark on exactly one rail (positive = `pos_rail` only, negative = `neg_rail` only) is a violation when its polarity equals the polarity of the last single-rail mark. Zeros between marks do not change the stored polarity. The first single-rail mark after reset is never a violation.
- R5: `bpv_flag` is high in exactly the output bit time in which the accused mark is on `nrz_out`, and low in all other bit times.
- R6: A bit time with both rails high is a one that is never flagged. It leaves the stored polarity unchanged.
- R7: `carrier_loss` goes high in the output bit time of the ZERO_LIMIT-th consecutive zero (default 32). It stays high while zeros continue.
- R8: `carrier_loss` goes low in the same output bit time in which the next one appears on `nrz_out`.
- R9: A run of ZERO_LIMIT-1 zeros followed by a one never raises `carrier_loss`.
- R10: While `rst` is high at a rising edge, the outputs are 0 after that edge. Reset also clears the zero counter and the stored polarity.
- R11: When both rails carry identical NRZ data, `nrz_out` reproduces that data one bit time later, and `bpv_flag` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_rail | input | 1 | Positive-mark rail from the line receiver |
| neg_rail | input | 1 | Negative-mark rail from the line receiver |
| nrz_out | output | 1 | Merged NRZ serial data |
| bpv_flag | output | 1 | Violation flag, aligned to the accused bit on `nrz_out` |
| carrier_loss | output | 1 | High after a long run of zeros |

## Verification
A stored polarity that is wrong or not cleared shows up at the ports on the very next single-rail mark: that mark is flagged when it should not be, or passes when it should be flagged. A zero counter that is off by one moves the rise of `carrier_loss` by one bit time, which shows up at the end of a run of exactly the limit, or one less than the limit. A flag taken from the wrong pipeline stage lands one bit time away from the mark it accuses, so every deliberate violation sequence exposes it in the cycle that follows.

// File: rtl/line_mon_pkg.sv
package line_mon_pkg;

    // One bit time's worth of rail samples
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    // Polarity of the most recent single-rail mark
    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } mark_pol_e;

    // Any rail high means a one on the merged stream
    function automatic logic is_mark(rail_pair_t s);
        return s.pos | s.neg;
    endfunction

    // Polarity of a bit; marks on both rails carry no polarity
    function automatic mark_pol_e single_pol(rail_pair_t s);
        if (s.pos && !s.neg) begin
            return POL_POS;
        end
        if (s.neg && !s.pos) begin
            return POL_NEG;
        end
        return POL_NONE;
    endfunction

endpackage

// File: rtl/rail_sampler.sv
module rail_sampler
    import line_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pos_in,
    input  logic       neg_in,
    output rail_pair_t sample
);

    // Rails are captured on the falling edge, half a bit before processing
    always_ff @(negedge clk) begin
        if (rst) begin
            sample <= '0;
        end else begin
            sample <= '{pos: pos_in, neg: neg_in};
        end
    end

endmodule

// File: rtl/ami_decoder.sv
module ami_decoder
    import line_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rail_pair_t sample,
    output logic       nrz,
    output logic       bpv
);

    mark_pol_e last_pol;
    mark_pol_e cur_pol;
    mark_pol_e next_pol;
    logic      viol;

    always_comb begin
        cur_pol  = single_pol(sample);
        viol     = (cur_pol != POL_NONE) && (cur_pol == last_pol);
        next_pol = (cur_pol != POL_NONE) ? cur_pol : last_pol;
    end

    // Data and flag leave through the same register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            last_pol <= POL_NONE;
            nrz      <= 1'b0;
            bpv      <= 1'b0;
        end else begin
            last_pol <= next_pol;
            nrz      <= is_mark(sample);
            bpv      <= viol;
        end
    end

endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
    parameter int unsigned LIMIT = 32,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic mark,
    output logic loss
);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_next;

    // Saturating count of consecutive zeros, including the current bit
    always_comb begin
        if (mark) begin
            run_next = '0;
        end else if (run_cnt == CW'(LIMIT)) begin
            run_next = run_cnt;
        end else begin
            run_next = run_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            loss    <= 1'b0;
        end else begin
            run_cnt <= run_next;
            loss    <= !mark && (run_next == CW'(LIMIT));
        end
    end

endmodule

// File: rtl/bipolar_line_monitor.sv
module bipolar_line_monitor
    import line_mon_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic pos_rail,
    input  logic neg_rail,
    output logic nrz_out,
    output logic bpv_flag,
    output logic carrier_loss
);

    localparam int unsigned CNT_W = $clog2(ZERO_LIMIT + 1);

    rail_pair_t smp;

    rail_sampler u_sampler (
        .clk    (clk),
        .rst    (rst),
        .pos_in (pos_rail),
        .neg_in (neg_rail),
        .sample (smp)
    );

    ami_decoder u_decoder (
        .clk    (clk),
        .rst    (rst),
        .sample (smp),
        .nrz    (nrz_out),
        .bpv    (bpv_flag)
    );

    zero_run_detector #(
        .LIMIT (ZERO_LIMIT),
        .CW    (CNT_W)
    ) u_zeros (
        .clk  (clk),
        .rst  (rst),
        .mark (is_mark(smp)),
        .loss (carrier_loss)
    );

endmodule

// File: rtl/line_mon_checker.sv
module line_mon_checker (
    input logic clk,
    input logic rst,
    input logic nrz_out,
    input logic bpv_flag,
    input logic carrier_loss
);

    // R5
    flag_on_mark_chk: assert property (@(posedge clk) disable iff (rst)
        bpv_flag |-> nrz_out);

    // R8
    mark_clears_loss_chk: assert property (@(posedge clk) disable iff (rst)
        nrz_out |-> !carrier_loss);

    // R7
    loss_holds_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(carrier_loss) && !nrz_out) |-> carrier_loss);

    // R7
    loss_rise_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(carrier_loss) |-> $past(!nrz_out));

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!nrz_out && !bpv_flag && !carrier_loss));

endmodule

bind bipolar_line_monitor line_mon_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .nrz_out      (nrz_out),
    .bpv_flag     (bpv_flag),
    .carrier_loss (carrier_loss)
);

// File: tb/tb_bipolar_line_monitor.sv
`timescale 1ns/1ps
module tb_bipolar_line_monitor;

    localparam int LIMIT = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pos_rail = 1'b0;
    logic neg_rail = 1'b0;
    logic nrz_out, bpv_flag, carrier_loss;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int    due;
        logic  nrz;
        logic  bpv;
        logic  cl;
        string req;
    } exp_t;
    exp_t sb[$];

    // bench model state: 0 none, 1 positive, 2 negative
    int m_pol = 0;
    int m_zeros = 0;
    logic m_cl = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bipolar_line_monitor dut (
        .clk(clk), .rst(rst), .pos_rail(pos_rail), .neg_rail(neg_rail),
        .nrz_out(nrz_out), .bpv_flag(bpv_flag), .carrier_loss(carrier_loss)
    );

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic model_push(logic p, logic n, string req);
        exp_t e;
        int pol;
        e.bpv = 1'b0;
        pol = (p && !n) ? 1 : ((n && !p) ? 2 : 0);
        if (pol != 0) begin
            if (pol == m_pol) e.bpv = 1'b1;
            m_pol = pol;
        end
        if (p || n) begin
            m_zeros = 0;
            m_cl = 1'b0;
        end else begin
            m_zeros++;
            if (m_zeros >= LIMIT) m_cl = 1'b1;
        end
        e.nrz = p | n;
        e.cl  = m_cl;
        e.req = req;
        e.due = cyc + 1;
        sb.push_back(e);
    endtask

    task automatic send_bit(logic p, logic n, string req);
        @(posedge clk); #1;
        pos_rail = p;
        neg_rail = n;
        model_push(p, n, req);
    endtask

    // drive one bit, then change the rails after the sampling edge
    task automatic send_glitch(logic p, logic n, string req);
        send_bit(p, n, req);
        #2;
        pos_rail = ~p;
        neg_rail = ~n;
    endtask

    task automatic do_reset(string req);
        @(posedge clk); #1;
        rst = 1'b1;
        pos_rail = 1'b0;
        neg_rail = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(req, "nrz_out in reset", nrz_out, 1'b0);
        check(req, "bpv_flag in reset", bpv_flag, 1'b0);
        check(req, "carrier_loss in reset", carrier_loss, 1'b0);
        m_pol = 0;
        m_zeros = 0;
        m_cl = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        model_push(1'b0, 1'b0, req);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk); #3;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "nrz_out", nrz_out, e.nrz);
                check(e.req, "bpv_flag", bpv_flag, e.bpv);
                check(e.req, "carrier_loss", carrier_loss, e.cl);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        // R10: initial reset
        do_reset("R10");

        // R3 R4: alternating marks with zeros, first mark never flagged
        send_bit(1, 0, "R4");
        send_bit(0, 0, "R3");
        send_bit(0, 1, "R4");
        send_bit(1, 0, "R3");
        send_bit(0, 0, "R3");
        send_bit(0, 1, "R4");

        // R5: back-to-back same polarity
        send_bit(0, 1, "R5");
        send_bit(1, 0, "R5");
        send_bit(1, 0, "R5");
        send_bit(1, 0, "R5");

        // R4: zeros between same-polarity marks keep the polarity
        send_bit(0, 0, "R4");
        send_bit(0, 0, "R4");
        send_bit(1, 0, "R4");
        send_bit(0, 1, "R4");

        // R6: both rails high is a one, unflagged, polarity kept (negative)
        send_bit(1, 1, "R6");
        send_bit(0, 1, "R6");
        send_bit(1, 1, "R6");
        send_bit(1, 0, "R6");

        // R1: rails flipped after the falling edge do not matter
        send_glitch(0, 1, "R1");
        send_glitch(0, 0, "R1");
        send_glitch(0, 1, "R1");

        // R2: one bit latency across rising edges
        send_bit(1, 0, "R2");
        send_bit(0, 0, "R2");

        // R9: LIMIT-1 zeros then a one
        for (int i = 0; i < LIMIT - 2; i++) send_bit(0, 0, "R9");
        send_bit(0, 1, "R9");

        // R7: exactly LIMIT zeros, then some more
        for (int i = 0; i < LIMIT + 5; i++) send_bit(0, 0, "R7");
        // R8: next one clears the alarm
        send_bit(0, 1, "R8");
        send_bit(0, 0, "R8");

        // R11: identical NRZ data on both rails
        lfsr = 8'hA5;
        for (int i = 0; i < 48; i++) begin
            send_bit(lfsr[0], lfsr[0], "R11");
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end

        // R10: reset during carrier loss, polarity cleared
        send_bit(1, 0, "R10");
        for (int i = 0; i < LIMIT + 2; i++) send_bit(0, 0, "R7");
        do_reset("R10");
        send_bit(1, 0, "R10");
        send_bit(0, 1, "R10");

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule